// File: doc/BRIEF.md
# Wraparound-Level Virtual Channel Selector

This block picks the virtual channel level that a packet takes on its next hop through a router of a unidirectional torus of N dimensions, each of radix K. Each link only carries traffic toward higher coordinates, and the link that leaves coordinate K-1 wraps back to coordinate 0. The network has N+1 channel levels. A packet moves up one level each time it takes a wrap link, whatever the dimension. The level therefore records how many wraps the packet has used, and a route that needs no more than N wraps can never close a channel dependence cycle.

The route itself comes from outside the block and may be adaptive: the caller presents the node's coordinates, the packet's destination, the dimension chosen for the hop, the level the packet arrived on, and a flag that marks a packet just injected at this node. One cycle later the block returns the level for the hop and a flag telling whether the hop crosses a wrap link. It also returns the positive distance still to travel in the chosen dimension, a flag that the packet has reached its destination, a flag for a dimension index that is out of range, and an error flag for a wrap that would take the level past N.

Top module: `vc_wrap_level_sel`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge.
- R2: `res_valid` equals the `req_valid` of the previous cycle. In a cycle after `req_valid` was low, every other output keeps its earlier value.
- R3: `wrap_hop` is 1 exactly when `hop_dim` is below N and the coordinate of `here` in dimension `hop_dim` equals K-1. Dimension d occupies bits [d*CW +: CW] of `here` and `dest`.
- R4: Without an error, `next_level` is the effective level plus 1 for a wrap hop and equals the effective level for any other hop.
- R5: When `fresh` is 1 the effective level is 0 and `arr_level` is ignored. Otherwise the effective level is `arr_level`.
- R6: `lvl_err` is 1 when a wrap hop starts from an effective level of N, or when the effective level is already above N. In both cases `next_level` equals the effective level.
- R7: A `hop_dim` of N or more sets `bad_dim` to 1, forces `wrap_hop` to 0 and leaves the level unchanged.
- R8: `arrived` is 1 exactly when `here` and `dest` match in every dimension.
- R9: `hop_dist` is (dest - here) mod K in dimension `hop_dim`, counted in the positive direction. It is 0 when `bad_dim` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Hop request present this cycle |
| fresh | input | 1 | Packet has just been injected at this node |
| arr_level | input | LW | Level the packet arrived on |
| hop_dim | input | DW | Dimension chosen for this hop |
| here | input | N*CW | Coordinates of this node |
| dest | input | N*CW | Coordinates of the destination |
| res_valid | output | 1 | Result present |
| next_level | output | LW | Level to use on the outgoing hop |
| wrap_hop | output | 1 | Hop takes a wrap link |
| lvl_err | output | 1 | Wrap would exceed level N, or the incoming level is illegal |
| bad_dim | output | 1 | Chosen dimension is out of range |
| arrived | output | 1 | Node is the destination |
| hop_dist | output | CW | Remaining positive distance in the chosen dimension |

## Verification
A wrong edge compare, or the wrong dimension selected by the mux, shows up one cycle after the request as a wrong `wrap_hop` and a `next_level` that is off by one. A bad offset subtraction shows as a wrong `hop_dist` in the same cycle, mainly when the destination coordinate is below the current one. An overflow rule that is wrong shows only on hops that wrap from level N, so those hops, together with freshly injected packets that carry stale levels, are applied both as directed cases and within random traffic. All outputs are registered with no state across requests apart from the hold, so every defect is visible in the cycle that follows the offending input.

// File: rtl/vcsel_pkg.sv
package vcsel_pkg;
  // width of an index able to hold the values 0..n
  function automatic int unsigned span_bits(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // width of an index able to hold the values 0..n-1
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/vcsel_dim_offset.sv
module vcsel_dim_offset #(
  parameter int unsigned K  = 4,
  parameter int unsigned CW = 2
) (
  input  logic [CW-1:0] cur,
  input  logic [CW-1:0] dst,
  output logic [CW-1:0] ofs,
  output logic          at_edge
);
  localparam logic [CW:0] RADIX = (CW+1)'(K);
  localparam logic [CW-1:0] EDGE = CW'(K - 1);

  logic [CW:0] wide;

  always_comb begin
    if (dst >= cur) wide = {1'b0, dst} - {1'b0, cur};
    else            wide = RADIX + {1'b0, dst} - {1'b0, cur};
    ofs     = wide[CW-1:0];
    at_edge = (cur == EDGE);
  end
endmodule

// File: rtl/vcsel_level_calc.sv
module vcsel_level_calc #(
  parameter int unsigned N  = 3,
  parameter int unsigned LW = 2
) (
  input  logic          wrap,
  input  logic          fresh,
  input  logic [LW-1:0] arr_level,
  output logic [LW-1:0] nxt,
  output logic          err
);
  localparam logic [LW-1:0] TOP = LW'(N);

  logic [LW-1:0] eff;

  always_comb begin
    eff = fresh ? '0 : arr_level;
    if (eff > TOP) begin
      err = 1'b1;
      nxt = eff;
    end else if (wrap && (eff == TOP)) begin
      err = 1'b1;
      nxt = eff;
    end else begin
      err = 1'b0;
      nxt = eff + LW'(wrap);
    end
  end

  always_comb begin
    if (!err) assert (nxt <= TOP) else $error("AST_LEVEL_BOUND"); // R6
  end
endmodule

// File: rtl/vc_wrap_level_sel.sv
module vc_wrap_level_sel
  import vcsel_pkg::*;
#(
  parameter int unsigned K  = 4,
  parameter int unsigned N  = 3,
  parameter int unsigned CW = idx_bits(K),
  parameter int unsigned LW = span_bits(N),
  parameter int unsigned DW = span_bits(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            fresh,
  input  logic [LW-1:0]   arr_level,
  input  logic [DW-1:0]   hop_dim,
  input  logic [N*CW-1:0] here,
  input  logic [N*CW-1:0] dest,
  output logic            res_valid,
  output logic [LW-1:0]   next_level,
  output logic            wrap_hop,
  output logic            lvl_err,
  output logic            bad_dim,
  output logic            arrived,
  output logic [CW-1:0]   hop_dist
);
  localparam logic [DW-1:0] DIMS = DW'(N);

  logic [CW-1:0] ofs  [N];
  logic [N-1:0]  edge_v;
  logic [N-1:0]  zero_v;

  for (genvar d = 0; d < N; d++) begin : g_dim
    vcsel_dim_offset #(.K(K), .CW(CW)) u_ofs (
      .cur    (here[d*CW +: CW]),
      .dst    (dest[d*CW +: CW]),
      .ofs    (ofs[d]),
      .at_edge(edge_v[d])
    );
    assign zero_v[d] = (ofs[d] == '0);
  end

  logic          c_bad;
  logic          c_wrap;
  logic [CW-1:0] c_dist;

  always_comb begin
    c_bad  = (hop_dim >= DIMS);
    c_wrap = 1'b0;
    c_dist = '0;
    for (int d = 0; d < N; d++) begin
      if (hop_dim == DW'(d)) begin
        c_wrap = edge_v[d];
        c_dist = ofs[d];
      end
    end
  end

  logic [LW-1:0] c_lvl;
  logic          c_err;

  vcsel_level_calc #(.N(N), .LW(LW)) u_lvl (
    .wrap     (c_wrap),
    .fresh    (fresh),
    .arr_level(arr_level),
    .nxt      (c_lvl),
    .err      (c_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      next_level <= '0;
      wrap_hop   <= 1'b0;
      lvl_err    <= 1'b0;
      bad_dim    <= 1'b0;
      arrived    <= 1'b0;
      hop_dist   <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        next_level <= c_lvl;
        wrap_hop   <= c_wrap;
        lvl_err    <= c_err;
        bad_dim    <= c_bad;
        arrived    <= &zero_v;
        hop_dist   <= c_dist;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(next_level) && $stable(hop_dist)); // R2
  AST_BAD_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    res_valid && bad_dim |-> !wrap_hop && hop_dist == '0); // R7
  AST_WRAP_RAISES: assert property (@(posedge clk) disable iff (rst)
    res_valid && wrap_hop && !lvl_err |-> next_level != '0); // R4
  AST_ARRIVED_DIST: assert property (@(posedge clk) disable iff (rst)
    res_valid && arrived && !bad_dim |-> hop_dist == '0); // R8
endmodule

// File: tb/vc_wrap_level_sel_bench.sv
`timescale 1ns/1ps
module vc_wrap_level_sel_bench;
  localparam int K = 4;
  localparam int N = 3;
  localparam int CW = 2;
  localparam int LW = 2;
  localparam int DW = 2;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, fresh;
  logic [LW-1:0] arr_level;
  logic [DW-1:0] hop_dim;
  logic [N*CW-1:0] here, dest;
  logic res_valid, wrap_hop, lvl_err, bad_dim, arrived;
  logic [LW-1:0] next_level;
  logic [CW-1:0] hop_dist;

  always #2 clk = ~clk;

  vc_wrap_level_sel #(.K(K), .N(N)) u_vc_wrap_level_sel (
    .clk(clk), .rst(rst), .req_valid(req_valid), .fresh(fresh),
    .arr_level(arr_level), .hop_dim(hop_dim), .here(here), .dest(dest),
    .res_valid(res_valid), .next_level(next_level), .wrap_hop(wrap_hop),
    .lvl_err(lvl_err), .bad_dim(bad_dim), .arrived(arrived), .hop_dist(hop_dist)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  int e_valid, e_lvl, e_wrap, e_err, e_bad, e_arr, e_dist;
  bit e_fresh;
  int cur_i[N];
  int dst_i[N];

  task automatic cmp(input string tag, input int act, input int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    vectors++;
    cmp("R2 res_valid", res_valid, e_valid);
    cmp("R3 wrap_hop", wrap_hop, e_wrap);
    cmp(e_fresh ? "R5 next_level" : "R4 next_level", next_level, e_lvl);
    cmp("R6 lvl_err", lvl_err, e_err);
    cmp("R7 bad_dim", bad_dim, e_bad);
    cmp("R8 arrived", arrived, e_arr);
    cmp("R9 hop_dist", hop_dist, e_dist);
  endtask

  task automatic drive(input bit v, input bit inj, input int lvl, input int dim);
    int eff;
    req_valid = v;
    fresh     = inj;
    arr_level = LW'(lvl);
    hop_dim   = DW'(dim);
    for (int d = 0; d < N; d++) begin
      here[d*CW +: CW] = CW'(cur_i[d]);
      dest[d*CW +: CW] = CW'(dst_i[d]);
    end
    e_valid = v;
    if (v) begin
      e_fresh = inj;
      e_bad  = (dim >= N);
      e_wrap = (!e_bad && cur_i[dim] == K - 1);
      e_dist = e_bad ? 0 : (dst_i[dim] - cur_i[dim] + K) % K;
      e_arr = 1;
      for (int d = 0; d < N; d++) if (cur_i[d] != dst_i[d]) e_arr = 0;
      eff = inj ? 0 : lvl;
      if (eff > N || (e_wrap && eff == N)) begin
        e_err = 1; e_lvl = eff;
      end else begin
        e_err = 0; e_lvl = eff + e_wrap;
      end
    end
  endtask

  task automatic step(input bit v, input bit inj, input int lvl, input int dim);
    drive(v, inj, lvl, dim);
    @(negedge clk);
    check_all();
  endtask

  task automatic set_c(input int a, input int b, input int c);
    cur_i[0] = a; cur_i[1] = b; cur_i[2] = c;
  endtask
  task automatic set_d(input int a, input int b, input int c);
    dst_i[0] = a; dst_i[1] = b; dst_i[2] = c;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b1; fresh = 1'b0; arr_level = '1; hop_dim = '0;
    here = '1; dest = '0;
    e_valid = 0; e_lvl = 0; e_wrap = 0; e_err = 0; e_bad = 0; e_arr = 0; e_dist = 0;
    e_fresh = 0;
    repeat (3) @(negedge clk);
    // R1: reset state, even with a valid request held on the inputs
    vectors++;
    cmp("R1 reset outputs", {res_valid, next_level, wrap_hop, lvl_err, bad_dim, arrived, hop_dist}, 0);
    rst = 1'b0;
    // plain hop, no wrap
    set_c(0, 0, 0); set_d(1, 2, 3); step(1, 0, 0, 0);
    // R3/R4 wrap in dimension 0 raises the level
    set_c(3, 0, 0); set_d(1, 0, 0); step(1, 0, 1, 0);
    // wrap in dimension 2 from level 2
    set_c(0, 0, 3); set_d(0, 0, 2); step(1, 0, 2, 2);
    // R6 wrap at level N overflows
    set_c(3, 3, 3); set_d(0, 0, 0); step(1, 0, 3, 2);
    // R5 injected packet ignores stale level
    step(1, 1, 3, 2);
    step(1, 1, 2, 1);
    // R7 out-of-range dimension
    step(1, 0, 1, 3);
    // R8 arrival
    set_c(2, 1, 3); set_d(2, 1, 3); step(1, 0, 1, 1);
    // R9 destination below current coordinate
    set_c(2, 0, 0); set_d(1, 0, 0); step(1, 0, 0, 0);
    // R2 idle cycles hold the fields while inputs move
    set_c(3, 3, 3); set_d(0, 1, 2); step(0, 1, 3, 0);
    step(0, 0, 0, 3);
    // non-wrap hop at level N stays legal
    set_c(1, 3, 3); set_d(2, 0, 0); step(1, 0, 3, 0);
    // random traffic
    for (int i = 0; i < 600; i++) begin
      for (int d = 0; d < N; d++) begin
        cur_i[d] = $urandom_range(K - 1);
        dst_i[d] = ($urandom_range(3) == 0) ? cur_i[d] : $urandom_range(K - 1);
      end
      step($urandom_range(4) != 0, $urandom_range(3) == 0,
           $urandom_range(N), $urandom_range(N));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule